// File: doc/BRIEF.md
# Multi-Port PHY Reset and Strap Configuration Controller

This block owns the reset and power-up configuration of a four-port Ethernet transceiver management core. One active-low hardware reset pin serves the whole device. It passes through a synchronizer and a low-time qualifier. Only a low level that lasts at least `MIN_LOW_CYCLES` clocks is taken as a real hardware reset. A qualified reset captures the configuration strap inputs and returns every port register to its default, including the fields whose defaults come from straps. Shorter dips leave all state alone.

Each port also has its own software reset. Setting the top bit of that port's control register starts a fixed-length sequence. During the sequence the port reports busy, the bit reads back as 1, and writes to that port are dropped. When the sequence ends the bit clears itself. A software reset re-samples no strap and restores no default. A qualified hardware reset that arrives during a software reset overrides it.

Every port exposes a 5-bit management address. Its default is the strapped upper bits followed by the port index, and software may overwrite it. While the synchronized reset pin is low, the block asks the management data pad to be held low.

Top module: `phy_rst_strap_ctrl`

## Requirements
- R1: After the synchronized reset pin has been low for `MIN_LOW_CYCLES` clocks (default 1000), every bit of `port_busy` is 1 and stays 1 while the pin remains low. All port registers take their defaults during that time.
- R2: A low pulse that ends before qualification has no effect on `strap_latched`, on any address or on any control register.
- R3: `mdio_hold_low` is 1 whenever the reset pin, delayed by the two-stage synchronizer, is low.
- R4: `strap_latched` is loaded during a qualified reset and holds afterwards. Bit layout: [0] auto-negotiation enable, [1] 10M full duplex, [2] 100M full duplex, [3] 100M half duplex, [4] fiber select, [5] serial MII enable, [8:6] address high bits. A strap bit whose `strap_driven` bit is 0 takes its pull value: 1 for bits [3:0] and 0 for bits [8:4].
- R5: The control register (address 0x00) defaults to a value derived from the captured straps. Bit 13 (speed 100) = bit2 | bit3. Bit 8 (full duplex) = bit2 when speed is 100, otherwise bit1. Bit 12 (auto-negotiation) = bit0 & ~bit4. All other bits default to 0.
- R6: The default address of port p is {strap bits [8:6], p[1:0]}. For example, strap value 100b gives ports 0 to 3 the addresses 0x10 to 0x13.
- R7: A write to address 0x19 loads `wdata[4:0]` into the selected port's address, which then appears on `port_addr`.
- R8: Writing bit 15 = 1 to port p's address 0x00 sets `port_busy[p]` for exactly 16 clocks. During those clocks bit 15 reads 1, and it reads 0 afterwards. Other ports are unaffected.
- R9: A software reset leaves the control bits, the addresses and `strap_latched` exactly as they were.
- R10: Writes addressed to a port whose software reset is running are ignored.
- R11: A qualified hardware reset cancels a software reset in progress. After release every port is idle and accepts writes at once.
- R12: Reads at 0x00 return stored bits [14:0] with bit 15 equal to that port's busy state. Reads at 0x19 return the address in [4:0] with zeros above it. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset pin |
| strap_in | input | 9 | Configuration strap levels |
| strap_driven | input | 9 | 1 where the matching strap is externally driven |
| reg_sel | input | 2 | Port selected for register access |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected port and address |
| port_busy | output | 4 | Per-port reset-in-progress |
| strap_latched | output | 9 | Captured strap values |
| port_addr | output | 20 | Port p's address in bits [5p+4:5p] |
| mdio_hold_low | output | 1 | Hold-low request for the management data pad |

## Verification
The embedded properties assume that the first qualified hardware reset precedes any meaningful register content. They also assume that a write strobe is a single clock per transaction. The properties are therefore disabled while the qualified reset is asserted, or while the raw pin is high for the qualifier. The bench respects both assumptions. It first holds the pin high long enough to flush the synchronizer, then applies a full-length reset before comparing anything. It issues every write as a one-clock strobe on a falling clock edge. Strap inputs change only while the pin is high, so the straps captured during each qualified window are well defined.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

   localparam int STRAP_W      = 9;
   localparam int STRAP_ADDR_W = 3;

   typedef struct packed {
      logic [STRAP_ADDR_W-1:0] addr_hi;
      logic                    ser_mii;
      logic                    fiber;
      logic                    hd100;
      logic                    fd100;
      logic                    fd10;
      logic                    an_en;
   } strap_t;

   localparam strap_t STRAP_PULL = '{addr_hi: '0, ser_mii: 1'b0, fiber: 1'b0,
                                     hd100: 1'b1, fd100: 1'b1, fd10: 1'b1, an_en: 1'b1};

   localparam int CTRL_RST_BIT    = 15;
   localparam int CTRL_SPEED_BIT  = 13;
   localparam int CTRL_AN_BIT     = 12;
   localparam int CTRL_DUPLEX_BIT = 8;
   localparam int CTRL_MIN_W      = 16;

   localparam logic [4:0] REG_CTRL = 5'h00;
   localparam logic [4:0] REG_ADDR = 5'h19;

   function automatic logic [CTRL_MIN_W-1:0] ctrl_default(input strap_t s);
      logic [CTRL_MIN_W-1:0] v;
      logic                  spd;
      spd = s.fd100 | s.hd100;
      v = '0;
      v[CTRL_SPEED_BIT]  = spd;
      v[CTRL_AN_BIT]     = s.an_en & ~s.fiber;
      v[CTRL_DUPLEX_BIT] = spd ? s.fd100 : s.fd10;
      return v;
   endfunction

endpackage

// File: rtl/phy_hwrst_qual.sv
module phy_hwrst_qual #(
   parameter int SYNC_STAGES    = 2,
   parameter int MIN_LOW_CYCLES = 1000,
   parameter bit HOLD_ON_RAW    = 1'b1
) (
   input  logic clk,
   input  logic rst_pin_n,
   output logic hw_active,
   output logic mdio_hold_low
);
   localparam int CNT_W = $clog2(MIN_LOW_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_LOW_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_LOW_CYCLES - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("phy_hwrst_qual: SYNC_STAGES must be at least 2");
   end
   if (MIN_LOW_CYCLES < 2) begin : g_bad_min
      $error("phy_hwrst_qual: MIN_LOW_CYCLES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic [CNT_W-1:0]       low_cnt;

   always_ff @(posedge clk) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin_n};
   end
   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (pin_s) begin
         low_cnt <= '0;
      end else if (low_cnt < CNT_MAX) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign hw_active = (low_cnt == CNT_MAX);

   if (HOLD_ON_RAW) begin : g_hold_raw
      assign mdio_hold_low = ~pin_s;
   end else begin : g_hold_qual
      assign mdio_hold_low = hw_active;
   end

   // R1
   qualify_reach_chk: assert property (@(posedge clk) disable iff (pin_s)
      (low_cnt == CNT_LAST) |=> hw_active);

endmodule

// File: rtl/phy_strap_latch.sv
module phy_strap_latch
   import phy_rst_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                    clk,
   input  logic                    capture,
   input  logic [STRAP_W-1:0]      strap_in,
   input  logic [STRAP_W-1:0]      strap_driven,
   output logic [STRAP_W-1:0]      strap_q,
   output logic [DATA_W-1:0]       def_ctrl,
   output logic [STRAP_ADDR_W-1:0] def_addr_hi
);
   strap_t merged;

   if (DATA_W < CTRL_MIN_W) begin : g_bad_dw
      $error("phy_strap_latch: DATA_W too small for the control layout");
   end

   assign merged = strap_t'((strap_in & strap_driven) | (STRAP_PULL & ~strap_driven));

   always_ff @(posedge clk) begin
      if (capture) begin
         strap_q <= merged;
      end
   end

   assign def_ctrl    = DATA_W'(ctrl_default(merged));
   assign def_addr_hi = merged.addr_hi;

   // R4
   strap_hold_chk: assert property (@(posedge clk) disable iff (capture)
      !capture |=> $stable(strap_q));

endmodule

// File: rtl/phy_port_regs.sv
module phy_port_regs
   import phy_rst_pkg::*;
#(
   parameter int PORT_IDX      = 0,
   parameter int ADDR_W        = 5,
   parameter int PORT_W        = 2,
   parameter int DATA_W        = 16,
   parameter int REG_AW        = 5,
   parameter int SW_RST_CYCLES = 16
) (
   input  logic                    clk,
   input  logic                    hw_active,
   input  logic [DATA_W-1:0]       def_ctrl,
   input  logic [STRAP_ADDR_W-1:0] def_addr_hi,
   input  logic                    wr_en,
   input  logic [REG_AW-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    busy,
   output logic [ADDR_W-1:0]       phy_addr
);
   localparam int SW_W = $clog2(SW_RST_CYCLES + 1);
   localparam logic [SW_W-1:0] SW_LOAD = SW_W'(SW_RST_CYCLES);
   localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(REG_CTRL);
   localparam logic [REG_AW-1:0] A_ADDR = REG_AW'(REG_ADDR);
   localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << CTRL_RST_BIT);

   if (SW_RST_CYCLES < 1) begin : g_bad_sw
      $error("phy_port_regs: SW_RST_CYCLES must be positive");
   end
   if (ADDR_W != STRAP_ADDR_W + PORT_W) begin : g_bad_aw
      $error("phy_port_regs: ADDR_W must equal strap address bits plus PORT_W");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SW_W-1:0]   sw_cnt;
   logic              sw_busy;
   logic              wr_ok;

   assign sw_busy = (sw_cnt != '0);
   assign wr_ok   = wr_en & ~sw_busy;
   assign busy    = hw_active | sw_busy;

   always_ff @(posedge clk) begin
      if (hw_active) begin
         ctrl_q <= def_ctrl;
         addr_q <= {def_addr_hi, PORT_W'(PORT_IDX)};
         sw_cnt <= '0;
      end else begin
         if (sw_busy) begin
            sw_cnt <= sw_cnt - 1'b1;
         end
         if (wr_ok && reg_addr == A_CTRL) begin
            ctrl_q <= wr_data & STORE_MASK;
            if (wr_data[CTRL_RST_BIT]) begin
               sw_cnt <= SW_LOAD;
            end
         end
         if (wr_ok && reg_addr == A_ADDR) begin
            addr_q <= wr_data[ADDR_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (reg_addr == A_CTRL) begin
         rd_data = ctrl_q & STORE_MASK;
         rd_data[CTRL_RST_BIT] = busy;
      end else if (reg_addr == A_ADDR) begin
         rd_data = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
      end
   end

   assign phy_addr = addr_q;

   // R8
   sw_countdown_chk: assert property (@(posedge clk) disable iff (hw_active)
      sw_busy |=> (sw_cnt == $past(sw_cnt) - 1'b1));

   // R10
   busy_write_drop_chk: assert property (@(posedge clk) disable iff (hw_active)
      (wr_en && sw_busy) |=> ($stable(ctrl_q) && $stable(addr_q)));

   // R11
   hw_cancels_sw_chk: assert property (@(posedge clk) disable iff (hw_active)
      $fell(hw_active) |-> !sw_busy);

endmodule

// File: rtl/phy_rst_strap_ctrl.sv
module phy_rst_strap_ctrl
   import phy_rst_pkg::*;
#(
   parameter int NUM_PORTS      = 4,
   parameter int ADDR_W         = 5,
   parameter int DATA_W         = 16,
   parameter int REG_AW         = 5,
   parameter int SYNC_STAGES    = 2,
   parameter int MIN_LOW_CYCLES = 1000,
   parameter int SW_RST_CYCLES  = 16,
   parameter bit HOLD_ON_RAW    = 1'b1,
   localparam int PORT_W        = $clog2(NUM_PORTS)
) (
   input  logic                        clk,
   input  logic                        hw_rst_n,
   input  logic [STRAP_W-1:0]          strap_in,
   input  logic [STRAP_W-1:0]          strap_driven,
   input  logic [PORT_W-1:0]           reg_sel,
   input  logic [REG_AW-1:0]           reg_addr,
   input  logic                        reg_wr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   output logic [NUM_PORTS-1:0]        port_busy,
   output logic [STRAP_W-1:0]          strap_latched,
   output logic [NUM_PORTS*ADDR_W-1:0] port_addr,
   output logic                        mdio_hold_low
);
   if (NUM_PORTS < 2 || (NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
      $error("phy_rst_strap_ctrl: NUM_PORTS must be a power of two, at least 2");
   end
   if (REG_AW < 5) begin : g_bad_raw
      $error("phy_rst_strap_ctrl: REG_AW must cover address 0x19");
   end

   logic                    hw_active;
   logic [DATA_W-1:0]       def_ctrl;
   logic [STRAP_ADDR_W-1:0] def_addr_hi;
   logic [DATA_W-1:0]       rd_vec [NUM_PORTS];

   phy_hwrst_qual #(
      .SYNC_STAGES   (SYNC_STAGES),
      .MIN_LOW_CYCLES(MIN_LOW_CYCLES),
      .HOLD_ON_RAW   (HOLD_ON_RAW)
   ) u_qual (
      .clk          (clk),
      .rst_pin_n    (hw_rst_n),
      .hw_active    (hw_active),
      .mdio_hold_low(mdio_hold_low)
   );

   phy_strap_latch #(
      .DATA_W(DATA_W)
   ) u_straps (
      .clk         (clk),
      .capture     (hw_active),
      .strap_in    (strap_in),
      .strap_driven(strap_driven),
      .strap_q     (strap_latched),
      .def_ctrl    (def_ctrl),
      .def_addr_hi (def_addr_hi)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      phy_port_regs #(
         .PORT_IDX     (p),
         .ADDR_W       (ADDR_W),
         .PORT_W       (PORT_W),
         .DATA_W       (DATA_W),
         .REG_AW       (REG_AW),
         .SW_RST_CYCLES(SW_RST_CYCLES)
      ) u_regs (
         .clk        (clk),
         .hw_active  (hw_active),
         .def_ctrl   (def_ctrl),
         .def_addr_hi(def_addr_hi),
         .wr_en      (reg_wr && (reg_sel == PORT_W'(p))),
         .reg_addr   (reg_addr),
         .wr_data    (reg_wdata),
         .rd_data    (rd_vec[p]),
         .busy       (port_busy[p]),
         .phy_addr   (port_addr[p*ADDR_W +: ADDR_W])
      );
   end

   assign reg_rdata = rd_vec[reg_sel];

endmodule

// File: tb/phy_rst_strap_ctrl_test.sv
module phy_rst_strap_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int MINL = 1000;
   localparam int SWC  = 16;
   localparam int NP   = 4;
   localparam int WATCHDOG = 100000;

   logic        clk = 1'b0;
   logic        hw_rst_n = 1'b1;
   logic [8:0]  strap_in = '0;
   logic [8:0]  strap_driven = '0;
   logic [1:0]  reg_sel = '0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  port_busy;
   logic [8:0]  strap_latched;
   logic [19:0] port_addr;
   logic        mdio_hold_low;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   phy_rst_strap_ctrl uut (
      .clk(clk), .hw_rst_n(hw_rst_n), .strap_in(strap_in), .strap_driven(strap_driven),
      .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .port_busy(port_busy), .strap_latched(strap_latched),
      .port_addr(port_addr), .mdio_hold_low(mdio_hold_low)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   bit          m_s1 = 1'b1, m_s2 = 1'b1, cmp_en = 1'b0, m_act;
   int          m_low = 0;
   logic [8:0]  m_strap;
   logic [15:0] m_ctrl [NP];
   logic [4:0]  m_addr [NP];
   int          m_cnt  [NP];

   function automatic logic [8:0] merge(input logic [8:0] v, input logic [8:0] d);
      return (v & d) | (9'h00F & ~d);
   endfunction

   function automatic logic [15:0] ctrl_def(input logic [8:0] s);
      logic spd;
      spd = s[2] | s[3];
      return (16'(spd) << 13) | (16'(s[0] & ~s[4]) << 12) | (16'(spd ? s[2] : s[1]) << 8);
   endfunction

   function automatic logic [15:0] m_read(input int p, input logic [4:0] a);
      if (a == 5'h00) return {((m_low == MINL) || (m_cnt[p] != 0)), m_ctrl[p][14:0]};
      if (a == 5'h19) return {11'b0, m_addr[p]};
      return 16'h0000;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      m_act = (m_low == MINL);
      if (m_act) begin
         m_strap = merge(strap_in, strap_driven);
         cmp_en = 1'b1;
         for (int p = 0; p < NP; p++) begin
            m_ctrl[p] = ctrl_def(m_strap);
            m_addr[p] = {m_strap[8:6], 2'(p)};
            m_cnt[p]  = 0;
         end
      end else begin
         for (int p = 0; p < NP; p++) begin
            bit ok;
            ok = reg_wr && (reg_sel == 2'(p)) && (m_cnt[p] == 0);
            if (m_cnt[p] != 0) m_cnt[p]--;
            if (ok && reg_addr == 5'h00) begin
               m_ctrl[p] = reg_wdata & 16'h7FFF;
               if (reg_wdata[15]) m_cnt[p] = SWC;
            end else if (ok && reg_addr == 5'h19) begin
               m_addr[p] = reg_wdata[4:0];
            end
         end
      end
      if (m_s2) m_low = 0;
      else if (m_low < MINL) m_low++;
      m_s2 = m_s1;
      m_s1 = hw_rst_n;
   end

   // clock-by-clock comparison against the model
   always @(negedge clk) begin
      #1;
      if (cmp_en) begin
         for (int p = 0; p < NP; p++) begin
            check("R1", 32'(port_busy[p]), 32'((m_low == MINL) || (m_cnt[p] != 0)));
            check("R7", 32'(port_addr[p*5 +: 5]), 32'(m_addr[p]));
         end
         check("R3", 32'(mdio_hold_low), 32'(!m_s2));
         check("R4", 32'(strap_latched), 32'(m_strap));
         check("R12", 32'(reg_rdata), 32'(m_read(int'(reg_sel), reg_addr)));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         fails++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] p, input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_sel = p; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] p, input logic [4:0] a,
                         input logic [15:0] exp);
      reg_sel = p; reg_addr = a;
      #2;
      check(req, 32'(reg_rdata), 32'(exp));
   endtask

   task automatic full_reset(input logic [8:0] v, input logic [8:0] d);
      @(negedge clk);
      strap_in = v; strap_driven = d;
      @(negedge clk);
      hw_rst_n = 1'b0;
      tick(MINL + 10);
      #2;
      check("R1", 32'(port_busy), 32'hF);
      check("R3", 32'(mdio_hold_low), 32'h1);
      hw_rst_n = 1'b1;
      tick(5);
      #2;
   endtask

   initial begin
      tick(5);
      // first reset, all straps left to their pulls
      full_reset(9'h000, 9'h000);
      check("R4", 32'(strap_latched), 32'h00F);
      for (int p = 0; p < NP; p++) check("R6", 32'(port_addr[p*5 +: 5]), 32'(p));
      check("R1", 32'(port_busy), 32'h0);
      rd_chk("R5", 2'd0, 5'h00, 16'h3100);
      rd_chk("R12", 2'd0, 5'h05, 16'h0000);

      // address rewrite and plain control write
      wr(2'd2, 5'h19, 16'hFFFA);
      rd_chk("R7", 2'd2, 5'h19, 16'h001A);
      check("R7", 32'(port_addr[10 +: 5]), 32'h1A);
      wr(2'd1, 5'h00, 16'h0123);
      rd_chk("R12", 2'd1, 5'h00, 16'h0123);

      // software reset on port 1
      wr(2'd1, 5'h00, 16'h8000);
      #2;
      check("R8", 32'(port_busy), 32'h2);
      rd_chk("R8", 2'd1, 5'h00, 16'h8000);
      wr(2'd1, 5'h19, 16'h0007);
      wr(2'd1, 5'h00, 16'h0055);
      #2;
      check("R10", 32'(port_addr[5 +: 5]), 32'h01);
      rd_chk("R10", 2'd1, 5'h00, 16'h8000);
      tick(14);
      #2;
      check("R8", 32'(port_busy), 32'h0);
      rd_chk("R9", 2'd1, 5'h00, 16'h0000);
      check("R9", 32'(strap_latched), 32'h00F);
      check("R9", 32'(port_addr[10 +: 5]), 32'h1A);

      // short pulse with new straps must change nothing
      @(negedge clk);
      strap_in = 9'h110; strap_driven = 9'h1FF;
      @(negedge clk);
      hw_rst_n = 1'b0;
      tick(200);
      #2;
      check("R3", 32'(mdio_hold_low), 32'h1);
      check("R2", 32'(port_busy), 32'h0);
      hw_rst_n = 1'b1;
      tick(5);
      #2;
      check("R2", 32'(strap_latched), 32'h00F);
      check("R2", 32'(port_addr[10 +: 5]), 32'h1A);
      rd_chk("R2", 2'd1, 5'h00, 16'h0000);

      // qualified reset arriving during a software reset on port 3
      @(negedge clk);
      hw_rst_n = 1'b0;
      tick(MINL - 8);
      wr(2'd3, 5'h00, 16'h8000);
      tick(30);
      #2;
      check("R11", 32'(port_busy), 32'hF);
      hw_rst_n = 1'b1;
      tick(5);
      #2;
      check("R11", 32'(port_busy), 32'h0);
      check("R4", 32'(strap_latched), 32'h110);
      for (int p = 0; p < NP; p++) check("R6", 32'(port_addr[p*5 +: 5]), 32'(16 + p));
      rd_chk("R5", 2'd0, 5'h00, 16'h0000);
      wr(2'd3, 5'h19, 16'h0009);
      #2;
      check("R11", 32'(port_addr[15 +: 5]), 32'h09);

      // partial strap drive: only 100M full duplex driven low
      full_reset(9'h000, 9'h004);
      check("R4", 32'(strap_latched), 32'h00B);
      rd_chk("R5", 2'd2, 5'h00, 16'h3000);
      check("R6", 32'(port_addr[15 +: 5]), 32'h03);

      tick(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule